// File: doc/BRIEF.md
# I2C Target Register-File Interface

This block is an I2C target that gives an external system controller access to a 256-entry, 8-bit host register area. It watches oversampled SCL and SDA lines in the system clock domain and finds START and STOP conditions. It matches a fixed 7-bit device address. It acknowledges received bytes by pulling SDA low through an open-drain enable.

In a write transfer, the first byte after the address byte loads an internal register pointer. Each later byte is stored at the pointer, and the pointer then advances, so one transfer can fill consecutive registers. In a read transfer, the target sends the register at the pointer and advances the pointer after each byte. It keeps sending while the master acknowledges and lets go of the bus after a NACK. The pointer wraps from the top of the area back to zero.

Each stored byte can raise a single-cycle interrupt to the core. The interrupt fires only when an enable bit in the command register is set.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `sda_oe_o` and `irq_o` are low and every host register reads back as 0x00.
- R2: An address byte whose upper seven bits equal 7'b1011100 (write form 0xB8 with LSB 0, read form 0xB9 with LSB 1) is acknowledged: SDA is low while SCL is high on the 9th clock.
- R3: Any other address byte is not acknowledged. The target then ignores every bit, and writes nothing, until the next START.
- R4: In a write transfer, the first byte after the address byte is acknowledged and loads the register pointer. It changes no register.
- R5: Each later byte in a write transfer is acknowledged and stored at the pointer, and the pointer then increments.
- R6: The pointer wraps from 0xFF to 0x00, for both writes and reads.
- R7: In a read transfer, the target sends the register at the pointer MSB first, with SDA changing only while SCL is low. It increments the pointer after each byte and releases SDA during the 9th clock.
- R8: When the master answers a read byte with NACK, the target drives SDA no more until a STOP or a START.
- R9: A repeated START re-enters address matching and keeps the pointer value left by the previous transfer.
- R10: Each stored data byte produces exactly one single-cycle `irq_o` pulse if bit 0 of register 0x00 (the command register) held 1 before that store. The bit's value from before the store decides the pulse, including when the store targets register 0x00 itself. Pointer-loading bytes never pulse.
- R11: A STOP releases SDA and returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the open-drain data line low |
| irq_o | output | 1 | Single-cycle write interrupt to the core |

## Verification
The store of a data byte and the interrupt decision happen in the same clock cycle. The decision reads the command register's enable bit while that same register may be taking a new value. The bench provokes this by writing 0x01 into register 0x00 while the enable is clear, and later 0x00 into it while the enable is set. A counter of `irq_o` pulses must show no pulse for the first write and exactly one for the second, since the pre-store value decides. Stores to other registers before and after each change confirm that the new enable value takes effect only from the next byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TACK,
        ST_IGNORE
    } tgt_state_e;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_SUB,
        ROLE_DATA
    } byte_role_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] pipe_q [STAGES];
    logic [1:0] last_q;
    logic [1:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= 2'b11;
        end else begin
            pipe_q[0] <= {scl_i, sda_i};
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q[g] <= 2'b11;
            end else begin
                pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 2'b11;
        end else begin
            last_q <= cur;
        end
    end

    assign cur        = pipe_q[STAGES-1];
    assign scl_o      = cur[1];
    assign sda_o      = cur[0];
    assign scl_rise_o = cur[1] & ~last_q[1];
    assign scl_fall_o = ~cur[1] & last_q[1];
    assign start_o    = cur[1] & last_q[1] & last_q[0] & ~cur[0];
    assign stop_o     = cur[1] & last_q[1] & ~last_q[0] & cur[0];
endmodule

// File: rtl/i2c_hostreg_file.sv
module i2c_hostreg_file #(
    parameter int PTR_W    = 8,
    parameter int DATA_W   = 8,
    parameter int CMD_ADDR = 0,
    parameter int EN_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_en_o
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o  = mem_q[addr_i];
    assign irq_en_o = mem_q[CMD_ADDR][EN_BIT];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5C,
    parameter int         PTR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rd_data_i,
    input  logic             irq_en_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_oe_o,
    output logic             irq_o
);
    localparam int CNT_W = 4;

    typedef struct packed {
        tgt_state_e       st;
        byte_role_e       role;
        logic             rw;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             oe;
        logic             irq;
        logic             mack;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.irq = 1'b0;
        wr_en_o   = 1'b0;
        if (start_i) begin
            ctx_d.st   = ST_RX;
            ctx_d.role = ROLE_ADDR;
            ctx_d.cnt  = '0;
            ctx_d.oe   = 1'b0;
            ctx_d.mack = 1'b0;
        end else if (stop_i) begin
            ctx_d.st = ST_IDLE;
            ctx_d.oe = 1'b0;
        end else begin
            unique case (ctx_q.st)
                ST_RX: begin
                    if (scl_rise_i && ctx_q.cnt < CNT_W'(8)) begin
                        ctx_d.sh  = {ctx_q.sh[6:0], sda_s_i};
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                    end else if (scl_fall_i && ctx_q.cnt == CNT_W'(8)) begin
                        unique case (ctx_q.role)
                            ROLE_ADDR: begin
                                if (ctx_q.sh[7:1] == DEV_ADDR) begin
                                    ctx_d.rw = ctx_q.sh[0];
                                    ctx_d.oe = 1'b1;
                                    ctx_d.st = ST_ACK;
                                end else begin
                                    ctx_d.st = ST_IGNORE;
                                end
                            end
                            ROLE_SUB: begin
                                ctx_d.ptr = PTR_W'(ctx_q.sh);
                                ctx_d.oe  = 1'b1;
                                ctx_d.st  = ST_ACK;
                            end
                            default: begin
                                wr_en_o   = 1'b1;
                                ctx_d.ptr = ctx_q.ptr + 1'b1;
                                ctx_d.irq = irq_en_i;
                                ctx_d.oe  = 1'b1;
                                ctx_d.st  = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        ctx_d.cnt = '0;
                        if (ctx_q.rw) begin
                            ctx_d.sh  = rd_data_i;
                            ctx_d.ptr = ctx_q.ptr + 1'b1;
                            ctx_d.oe  = ~rd_data_i[7];
                            ctx_d.st  = ST_TX;
                        end else begin
                            ctx_d.oe   = 1'b0;
                            ctx_d.role = (ctx_q.role == ROLE_ADDR) ? ROLE_SUB : ROLE_DATA;
                            ctx_d.st   = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (ctx_q.cnt == CNT_W'(7)) begin
                            ctx_d.oe = 1'b0;
                            ctx_d.st = ST_TACK;
                        end else begin
                            ctx_d.sh  = {ctx_q.sh[6:0], 1'b0};
                            ctx_d.cnt = ctx_q.cnt + 1'b1;
                            ctx_d.oe  = ~ctx_q.sh[6];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise_i) begin
                        ctx_d.mack = ~sda_s_i;
                    end else if (scl_fall_i) begin
                        if (ctx_q.mack) begin
                            ctx_d.cnt = '0;
                            ctx_d.sh  = rd_data_i;
                            ctx_d.ptr = ctx_q.ptr + 1'b1;
                            ctx_d.oe  = ~rd_data_i[7];
                            ctx_d.st  = ST_TX;
                        end else begin
                            ctx_d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, role: ROLE_ADDR, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign ptr_o     = ctx_q.ptr;
    assign wr_data_o = ctx_q.sh;
    assign sda_oe_o  = ctx_q.oe;
    assign irq_o     = ctx_q.irq;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h5C,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         CMD_ADDR    = 0,
    parameter int         IRQ_EN_BIT  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic irq_o
);
    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en, irq_en;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
        .rd_data_i(rd_data), .irq_en_i(irq_en), .wr_en_o(wr_en), .ptr_o(ptr),
        .wr_data_o(wr_data), .sda_oe_o(sda_oe_o), .irq_o(irq_o)
    );

    i2c_hostreg_file #(.PTR_W(PTR_W), .DATA_W(8), .CMD_ADDR(CMD_ADDR), .EN_BIT(IRQ_EN_BIT)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en), .addr_i(ptr), .wdata_i(wr_data),
        .rdata_o(rd_data), .irq_en_o(irq_en)
    );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_o,
    input logic sda_oe_o,
    input logic wr_en,
    input logic start_det,
    input logic stop_det,
    input logic scl_s
);
    // R10: the interrupt never lasts more than one cycle
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10: an interrupt only follows a register store
    assert_irq_after_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(wr_en));

    // R11: STOP releases the data line
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R9: START (including repeated START) releases the data line
    assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R7: the target's drive on SDA changes only while SCL is low
    assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk chk_i (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .sda_oe_o(sda_oe_o),
    .wr_en(wr_en), .start_det(start_det), .stop_det(stop_det), .scl_s(scl_s)
);

// File: tb/i2c_regfile_target_tb_top.sv
module i2c_regfile_target_tb_top;
    localparam int Q       = 8;
    localparam int NVEC    = 6;
    localparam logic [7:0] AW = 8'hB8;
    localparam logic [7:0] AR = 8'hB9;
    // {register, value}
    localparam logic [15:0] VEC [NVEC] = '{16'h10A5, 16'h113C, 16'h7F80,
                                           16'h8001, 16'hFEFF, 16'h415A};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_i, sda_oe_o, irq_o;
    int   n_chk = 0;
    int   n_fail = 0;
    int   irq_cnt = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;
    assign sda_i = ~(m_low | sda_oe_o);

    i2c_regfile_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_i),
        .sda_oe_o(sda_oe_o), .irq_o(irq_o)
    );

    always @(negedge clk) if (irq_o) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; qw(); m_scl = 1'b1; qw(); m_low = 1'b1; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qw(); m_scl = 1'b1; qw(); m_low = 1'b0; qw();
    endtask

    task automatic bit_cyc(input logic b, output logic s);
        m_low = ~b; qw(); m_scl = 1'b1; qw(); s = sda_i; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            d[i] = s;
        end
        bit_cyc(~mack, s);
    endtask

    task automatic wr1(input logic [7:0] sub, input logic [7:0] v);
        logic a;
        bus_start(); send(AW, a); send(sub, a); send(v, a); bus_stop();
    endtask

    task automatic rd1(input logic [7:0] sub, output logic [7:0] d);
        logic a;
        bus_start(); send(AW, a); send(sub, a);
        bus_start(); send(AR, a); recv(1'b0, d); bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] d, d2;
        int         base;
        repeat (4) @(negedge clk);
        chk("R1 oe after reset", sda_oe_o, 0);
        chk("R1 irq after reset", irq_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd1(8'h10, d);
        chk("R1 register reset value", d, 8'h00);

        // vector table: store then read back
        for (int v = 0; v < NVEC; v++) begin
            wr1(VEC[v][15:8], VEC[v][7:0]);
        end
        for (int v = 0; v < NVEC; v++) begin
            rd1(VEC[v][15:8], d);
            chk("R5/R7 vector readback", d, {24'h0, VEC[v][7:0]});
        end
        chk("R10 no irq while enable clear", irq_cnt, 0);

        // R2 / R4 / R5 acks and multi-byte store
        bus_start();
        send(AW, a);   chk("R2 address ack", a, 1);
        send(8'h20, a); chk("R4 sub-address ack", a, 1);
        send(8'h01, a); chk("R5 data ack", a, 1);
        send(8'h02, a);
        send(8'h03, a);
        bus_stop();
        bus_start(); send(AW, a); send(8'h20, a);
        bus_start(); send(AR, a); chk("R2 read address ack", a, 1);
        recv(1'b1, d); recv(1'b1, d2);
        chk("R5 multi store byte0", d, 8'h01);
        chk("R7 multi read byte1", d2, 8'h02);
        recv(1'b0, d);
        chk("R7 multi read byte2", d, 8'h03);
        // R8: after NACK the target drives nothing
        recv(1'b0, d);
        chk("R8 released after nack", d, 8'hFF);
        bus_stop();
        chk("R11 released after stop", sda_oe_o, 0);

        // R4: sub-address-only transfer writes nothing
        bus_start(); send(AW, a); send(8'h11, a); bus_stop();
        rd1(8'h11, d);
        chk("R4 sub-address changes no register", d, 8'h3C);

        // R3: wrong address ignored
        bus_start();
        send(8'hBA, a); chk("R3 wrong address nack", a, 0);
        send(8'h30, a); chk("R3 ignored byte nack", a, 0);
        send(8'h77, a);
        bus_stop();
        rd1(8'h30, d);
        chk("R3 nothing stored", d, 8'h00);

        // R9: repeated start keeps pointer
        bus_start(); send(AW, a); send(8'h40, a); send(8'hAA, a);
        bus_start(); send(AR, a); recv(1'b0, d); bus_stop();
        chk("R9 pointer kept over restart", d, 8'h5A);

        // R6: wrap
        bus_start(); send(AW, a); send(8'hFF, a); send(8'h11, a); send(8'h22, a); bus_stop();
        bus_start(); send(AW, a); send(8'hFF, a);
        bus_start(); send(AR, a); recv(1'b1, d); recv(1'b0, d2); bus_stop();
        chk("R6 top register", d, 8'h11);
        chk("R6 wrapped to register 0", d2, 8'h22);
        chk("R10 still no irq", irq_cnt, 0);

        // R10: enable written while clear -> no pulse for that store
        wr1(8'h00, 8'h01);
        repeat (4) @(negedge clk);
        chk("R10 enabling store gives no pulse", irq_cnt, 0);
        wr1(8'h50, 8'h33);
        repeat (4) @(negedge clk);
        chk("R10 one pulse per store", irq_cnt, 1);
        base = irq_cnt;
        bus_start(); send(AW, a); send(8'h51, a); send(8'h34, a); send(8'h35, a); bus_stop();
        repeat (4) @(negedge clk);
        chk("R10 two stores two pulses", irq_cnt - base, 2);
        base = irq_cnt;
        bus_start(); send(AW, a); send(8'h52, a); bus_stop();
        chk("R10 sub-address byte no pulse", irq_cnt - base, 0);
        wr1(8'h00, 8'h00);
        repeat (4) @(negedge clk);
        chk("R10 disabling store still pulses", irq_cnt - base, 1);
        wr1(8'h53, 8'h44);
        repeat (4) @(negedge clk);
        chk("R10 no pulse after disable", irq_cnt - base, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule